// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor core that completes one instruction on every rising clock edge. In a single cycle it fetches a word from a local instruction store, decodes it and reads two source registers. It then runs the operation and writes the result back to a 32-entry register file. The instruction store is a word-addressed array indexed by the program counter. The environment fills it before releasing reset. The core has no data memory, no jumps and no pipeline.

The core supports seven register-register operations and six immediate or branch operations. The register-register set is unsigned add, unsigned subtract, AND, OR, signed set-less-than, arithmetic right shift by a constant, and arithmetic right shift by a register amount. The immediate and branch set is add immediate, unsigned set-less-than immediate, OR immediate, load upper immediate, branch if equal, and branch if not equal. The main decoder issues a 3-bit operation class. The ALU control step turns that class, and the function field for register-register words, into a concrete ALU operation. Each opcode chooses sign or zero extension of its immediate.

A combinational debug port reads any register, so the environment can inspect results.

Top module: `sc_core`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), the PC is 0 and every register reads 0. After release, the first instruction executed is the word at index 0.
- R2: Opcode 000000 with funct 100001 writes rs+rt, and funct 100011 writes rs-rt. Both wrap modulo 2^32 and go to register rd. The fields are rs bits 25:21, rt bits 20:16, rd bits 15:11 and funct bits 5:0.
- R3: Opcode 000000 with funct 100100 writes rs AND rt into rd, and funct 100101 writes rs OR rt into rd.
- R4: Opcode 000000 with funct 101010 writes 1 into rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 001000 writes rs plus the sign-extended 16-bit immediate (bits 15:0) into rt. Opcode 001011 writes 1 into rt when rs is below the sign-extended immediate, compared unsigned, and 0 otherwise.
- R6: Opcode 001101 writes rs OR the zero-extended immediate into rt. Opcode 001111 writes the immediate into bits 31:16 of rt and zero into bits 15:0.
- R7: Funct 000011 writes rt shifted arithmetically right by shamt (bits 10:6) into rd, and the rs field has no effect. Funct 000111 shifts rt arithmetically right by bits 4:0 of register rs.
- R8: Opcode 000100 branches when rs equals rt, and opcode 000101 branches when they differ. A taken branch sets PC to PC+4 plus the sign-extended offset shifted left by 2. Otherwise PC becomes PC+4. Branches write no register.
- R9: Writes aimed at register 0 are dropped, and register 0 always reads 0. Any other opcode or funct changes no register, including the all-zero word.
- R10: `dbg_val_o` shows the register selected by `dbg_sel_i` combinationally, with no clock edge needed.
- R11: Each rising edge out of reset retires exactly one instruction, so after k edges exactly the first k instructions of straight-line code have taken effect. A branch-if-not-equal counted loop is the one closed backward branch this covers. The loop reaches the same final registers as an instruction-by-instruction evaluation, with no extra or missing iteration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock; one instruction retires per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of PC and registers |
| dbg_sel_i | input | 5 | Register index for the debug read |
| dbg_val_o | output | 32 | Contents of the selected register |

## Verification
The branch decision and the program counter cannot be seen at the ports, because only register contents come out. The stimulus places a marker write right after each branch, so a wrongly taken or wrongly skipped branch leaves a visible trace in a register. Every program ends in a branch-to-itself, so the core parks on a known word. Results are read after an exact number of edges, which exposes a missing or extra cycle. A backward counted loop checks target arithmetic with a negative offset. The sweep pairs boundary operands such as 0x80000000, 0x7fffffff and all-ones. Each pair runs the full operation mix, writes to register 0, unsupported encodings and a shift whose unused rs field is nonzero.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int unsigned XLEN = 32;

  typedef logic [5:0] opc_t;

  localparam opc_t OPC_RTYPE = 6'b000000;
  localparam opc_t OPC_BEQ   = 6'b000100;
  localparam opc_t OPC_BNE   = 6'b000101;
  localparam opc_t OPC_ADDI  = 6'b001000;
  localparam opc_t OPC_SLTIU = 6'b001011;
  localparam opc_t OPC_ORI   = 6'b001101;
  localparam opc_t OPC_LUI   = 6'b001111;

  localparam logic [5:0] FN_SRA  = 6'b000011;
  localparam logic [5:0] FN_SRAV = 6'b000111;
  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_SUBU = 6'b100011;
  localparam logic [5:0] FN_AND  = 6'b100100;
  localparam logic [5:0] FN_OR   = 6'b100101;
  localparam logic [5:0] FN_SLT  = 6'b101010;

  // operation class from the main decoder (low codes keep the legacy meaning)
  typedef enum logic [2:0] {
    AOP_ADD   = 3'b000,
    AOP_SUB   = 3'b001,
    AOP_FUNCT = 3'b010,
    AOP_SLTU  = 3'b011,
    AOP_OR    = 3'b100,
    AOP_LUI   = 3'b101
  } aluop_e;

  typedef enum logic [3:0] {
    ALU_AND   = 4'd0,
    ALU_OR    = 4'd1,
    ALU_ADD   = 4'd2,
    ALU_SLTU  = 4'd3,
    ALU_SRA_I = 4'd4,
    ALU_SRA_V = 4'd5,
    ALU_SUB   = 4'd6,
    ALU_SLT   = 4'd7,
    ALU_LUI   = 4'd8,
    ALU_NONE  = 4'd15
  } aluctl_e;

  typedef struct packed {
    logic   reg_write;
    logic   dst_is_rd;
    logic   src_is_imm;
    logic   zero_ext;
    logic   is_beq;
    logic   is_bne;
    aluop_e alu_op;
  } ctrl_t;

  typedef struct packed {
    opc_t       opcode;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] rd;
    logic [4:0] shamt;
    logic [5:0] funct;
  } rfmt_t;

  function automatic logic [XLEN-1:0] f_sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_zext16(input logic [15:0] v);
    return {{(XLEN-16){1'b0}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_sra(input logic [XLEN-1:0] v, input logic [4:0] amt);
    logic signed [XLEN-1:0] s;
    s = $signed(v);
    return $unsigned(s >>> amt);
  endfunction

  function automatic logic [XLEN-1:0] f_less(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                             input logic sgn);
    logic lt;
    if (sgn) lt = ($signed(a) < $signed(b));
    else     lt = (a < b);
    return {{(XLEN-1){1'b0}}, lt};
  endfunction

  function automatic logic [XLEN-1:0] f_br_target(input logic [XLEN-1:0] seq, input logic [15:0] off);
    logic [XLEN-1:0] ext;
    ext = f_sext16(off);
    return seq + {ext[XLEN-3:0], 2'b00};
  endfunction

endpackage

// File: rtl/sc_imem.sv
module sc_imem
  import sc_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic [AW-1:0]   addr_i,
  output logic [XLEN-1:0] data_o
);

  // contents are filled by the environment before reset is released
  logic [XLEN-1:0] rom_q [WORDS];

  initial begin
    for (int i = 0; i < int'(WORDS); i++) rom_q[i] = '0;
  end

  assign data_o = rom_q[addr_i];

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned RAW = $clog2(NUM_REGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RAW-1:0]  waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [RAW-1:0]  ra1_i,
  output logic [XLEN-1:0] rd1_o,
  input  logic [RAW-1:0]  ra2_i,
  output logic [XLEN-1:0] rd2_o,
  input  logic [RAW-1:0]  ra3_i,
  output logic [XLEN-1:0] rd3_o
);

  logic [NUM_REGS-1:0][XLEN-1:0] regs_q;
  logic                          wr_ok;

  assign wr_ok = we_i && (waddr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (wr_ok) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];
  assign rd3_o = (ra3_i == '0) ? '0 : regs_q[ra3_i];

endmodule

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  opc_t       opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o,
  output aluctl_e    alu_ctl_o
);

  ctrl_t   main_c;
  aluctl_e ctl_c;

  // main decoder: opcode to control word and operation class
  always_comb begin
    main_c        = '0;
    main_c.alu_op = AOP_ADD;
    unique case (opcode_i)
      OPC_RTYPE: begin
        main_c.reg_write = 1'b1;
        main_c.dst_is_rd = 1'b1;
        main_c.alu_op    = AOP_FUNCT;
      end
      OPC_ADDI: begin
        main_c.reg_write  = 1'b1;
        main_c.src_is_imm = 1'b1;
        main_c.alu_op     = AOP_ADD;
      end
      OPC_SLTIU: begin
        main_c.reg_write  = 1'b1;
        main_c.src_is_imm = 1'b1;
        main_c.alu_op     = AOP_SLTU;
      end
      OPC_ORI: begin
        main_c.reg_write  = 1'b1;
        main_c.src_is_imm = 1'b1;
        main_c.zero_ext   = 1'b1;
        main_c.alu_op     = AOP_OR;
      end
      OPC_LUI: begin
        main_c.reg_write  = 1'b1;
        main_c.src_is_imm = 1'b1;
        main_c.zero_ext   = 1'b1;
        main_c.alu_op     = AOP_LUI;
      end
      OPC_BEQ: begin
        main_c.is_beq = 1'b1;
        main_c.alu_op = AOP_SUB;
      end
      OPC_BNE: begin
        main_c.is_bne = 1'b1;
        main_c.alu_op = AOP_SUB;
      end
      default: main_c = '0;
    endcase
  end

  // ALU control: operation class plus funct to a concrete operation
  always_comb begin
    unique case (main_c.alu_op)
      AOP_ADD:  ctl_c = ALU_ADD;
      AOP_SUB:  ctl_c = ALU_SUB;
      AOP_SLTU: ctl_c = ALU_SLTU;
      AOP_OR:   ctl_c = ALU_OR;
      AOP_LUI:  ctl_c = ALU_LUI;
      AOP_FUNCT: begin
        unique case (funct_i)
          FN_ADDU: ctl_c = ALU_ADD;
          FN_SUBU: ctl_c = ALU_SUB;
          FN_AND:  ctl_c = ALU_AND;
          FN_OR:   ctl_c = ALU_OR;
          FN_SLT:  ctl_c = ALU_SLT;
          FN_SRA:  ctl_c = ALU_SRA_I;
          FN_SRAV: ctl_c = ALU_SRA_V;
          default: ctl_c = ALU_NONE;
        endcase
      end
      default: ctl_c = ALU_NONE;
    endcase
  end

  always_comb begin
    ctrl_o = main_c;
    if (ctl_c == ALU_NONE) ctrl_o.reg_write = 1'b0;
  end

  assign alu_ctl_o = ctl_c;

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [4:0]      shamt_i,
  input  aluctl_e         ctl_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);

  always_comb begin
    unique case (ctl_i)
      ALU_AND:   y_o = a_i & b_i;
      ALU_OR:    y_o = a_i | b_i;
      ALU_ADD:   y_o = a_i + b_i;
      ALU_SUB:   y_o = a_i - b_i;
      ALU_SLT:   y_o = f_less(a_i, b_i, 1'b1);
      ALU_SLTU:  y_o = f_less(a_i, b_i, 1'b0);
      ALU_SRA_I: y_o = f_sra(b_i, shamt_i);
      ALU_SRA_V: y_o = f_sra(b_i, a_i[4:0]);
      ALU_LUI:   y_o = {b_i[15:0], {(XLEN-16){1'b0}}};
      default:   y_o = '0;
    endcase
  end

  assign zero_o = (y_o == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  dbg_sel_i,
  output logic [31:0] dbg_val_o
);

  localparam int unsigned IMEM_AW  = $clog2(IMEM_WORDS);
  localparam int unsigned NUM_REGS = 32;

  // named internal events, visible to the bound checker
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] pc_next;
  logic [XLEN-1:0] instr;
  rfmt_t           fld;
  ctrl_t           ctrl;
  aluctl_e         alu_ctl;
  logic [XLEN-1:0] rs_val;
  logic [XLEN-1:0] rt_val;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic            alu_zero;
  logic            branch_taken;
  logic            rf_we;
  logic [4:0]      rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  sc_imem #(.WORDS(IMEM_WORDS)) u_imem (
    .addr_i (pc_q[IMEM_AW+1:2]),
    .data_o (instr)
  );

  assign fld = rfmt_t'(instr);

  sc_decoder u_dec (
    .opcode_i  (fld.opcode),
    .funct_i   (fld.funct),
    .ctrl_o    (ctrl),
    .alu_ctl_o (alu_ctl)
  );

  sc_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .ra1_i   (fld.rs),
    .rd1_o   (rs_val),
    .ra2_i   (fld.rt),
    .rd2_o   (rt_val),
    .ra3_i   (dbg_sel_i),
    .rd3_o   (dbg_val_o)
  );

  assign imm_ext = ctrl.zero_ext ? f_zext16(instr[15:0]) : f_sext16(instr[15:0]);
  assign alu_b   = ctrl.src_is_imm ? imm_ext : rt_val;

  sc_alu u_alu (
    .a_i     (rs_val),
    .b_i     (alu_b),
    .shamt_i (fld.shamt),
    .ctl_i   (alu_ctl),
    .y_o     (alu_y),
    .zero_o  (alu_zero)
  );

  assign branch_taken = (ctrl.is_beq && alu_zero) || (ctrl.is_bne && !alu_zero);

  assign pc_plus4 = pc_q + XLEN'(4);
  assign pc_next  = branch_taken ? f_br_target(pc_plus4, instr[15:0]) : pc_plus4;

  assign rf_we    = ctrl.reg_write;
  assign rf_waddr = ctrl.dst_is_rd ? fld.rd : fld.rt;
  assign rf_wdata = alu_y;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic            branch_taken,
  input logic            rf_we,
  input logic [4:0]      rf_waddr,
  input logic [XLEN-1:0] rf_wdata
);

  logic [5:0] op;
  logic [5:0] fn;
  logic       is_br;
  logic       known;

  assign op    = instr[31:26];
  assign fn    = instr[5:0];
  assign is_br = (op == OPC_BEQ) || (op == OPC_BNE);
  assign known = (op == OPC_ADDI) || (op == OPC_SLTIU) || (op == OPC_ORI) || (op == OPC_LUI) ||
                 ((op == OPC_RTYPE) && ((fn == FN_ADDU) || (fn == FN_SUBU) || (fn == FN_AND) ||
                  (fn == FN_OR) || (fn == FN_SLT) || (fn == FN_SRA) || (fn == FN_SRAV)));

  assert_pc_held_R1: assert property (@(posedge clk_i) !rst_ni |-> pc_q == '0);

  assert_seq_pc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !branch_taken |=> pc_q == $past(pc_q) + 32'd4);

  assert_branch_tgt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_taken |=> pc_q == $past(pc_q) + 32'd4 +
                     {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  assert_branch_cond_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_taken |-> ((op == OPC_BEQ) && (rs_val == rt_val)) ||
                     ((op == OPC_BNE) && (rs_val != rt_val)));

  assert_branch_nowb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_br |-> !rf_we);

  assert_rdest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we && (op == OPC_RTYPE)) |-> rf_waddr == instr[15:11]);

  assert_idest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we && (op != OPC_RTYPE)) |-> rf_waddr == instr[20:16]);

  assert_sltiu_bool_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we && (op == OPC_SLTIU)) |-> rf_wdata[31:1] == '0);

  assert_lui_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we && (op == OPC_LUI)) |-> rf_wdata[15:0] == '0);

  assert_unsup_nowb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> !rf_we);

endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pc_q         (pc_q),
  .instr        (instr),
  .rs_val       (rs_val),
  .rt_val       (rt_val),
  .branch_taken (branch_taken),
  .rf_we        (rf_we),
  .rf_waddr     (rf_waddr),
  .rf_wdata     (rf_wdata)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;

  localparam int PW = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_val;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] prog   [PW];
  logic [31:0] ref_rf [32];
  logic [31:0] vals   [12];

  always #2 clk = ~clk;

  sc_core dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .dbg_sel_i (dbg_sel),
    .dbg_val_o (dbg_val)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd,
                                        input logic [4:0] sh, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] halt_word();
    return enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return v[15] ? (32'hFFFF0000 | {16'h0, v}) : {16'h0, v};
  endfunction

  // arithmetic right shift written as logical shift plus sign fill
  function automatic logic [31:0] asr(input logic [31:0] v, input int n);
    logic [31:0] fill;
    fill = v[31] ? ~(32'hFFFFFFFF >> n) : 32'h0;
    return (v >> n) | fill;
  endfunction

  // instruction-by-instruction evaluation of prog[] from the requirements
  task automatic iss_run(output int steps);
    int pc;
    steps = 0;
    pc = 0;
    for (int r = 0; r < 32; r++) ref_rf[r] = 32'h0;
    while (prog[pc] != halt_word() && steps < 1000) begin
      logic [31:0] w, a, b, res;
      logic [5:0]  op, fn;
      int          dst, nxt;
      logic        wr;
      w  = prog[pc];
      op = w[31:26];
      fn = w[5:0];
      a  = ref_rf[w[25:21]];
      b  = ref_rf[w[20:16]];
      wr = 1'b0;
      res = 32'h0;
      dst = int'(w[20:16]);
      nxt = pc + 1;
      if (op == 6'b000000) begin
        dst = int'(w[15:11]);
        wr = 1'b1;
        case (fn)
          6'b100001: res = a + b;
          6'b100011: res = a - b;
          6'b100100: res = a & b;
          6'b100101: res = a | b;
          6'b101010: res = ((a[31] && !b[31]) || ((a[31] == b[31]) && (a < b))) ? 32'd1 : 32'd0;
          6'b000011: res = asr(b, int'(w[10:6]));
          6'b000111: res = asr(b, int'(a[4:0]));
          default:   wr = 1'b0;
        endcase
      end else begin
        case (op)
          6'b001000: begin wr = 1'b1; res = a + sx(w[15:0]); end
          6'b001011: begin wr = 1'b1; res = (a < sx(w[15:0])) ? 32'd1 : 32'd0; end
          6'b001101: begin wr = 1'b1; res = a | {16'h0, w[15:0]}; end
          6'b001111: begin wr = 1'b1; res = {w[15:0], 16'h0}; end
          6'b000100: if (a == b) nxt = pc + 1 + $signed(w[15:0]);
          6'b000101: if (a != b) nxt = pc + 1 + $signed(w[15:0]);
          default: ;
        endcase
      end
      if (wr && dst != 0) ref_rf[dst] = res;
      pc = nxt;
      steps++;
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic rd_reg(input int r, output logic [31:0] v);
    dbg_sel = r[4:0];
    #0.2;
    v = dbg_val;
  endtask

  function automatic string tag_of(input int r);
    case (r)
      1, 2, 12, 16: return "R6";
      3, 4:         return "R2";
      5, 6:         return "R3";
      7:            return "R4";
      8, 9:         return "R5";
      10, 11:       return "R7";
      13, 14:       return "R8";
      default:      return "R9";
    endcase
  endfunction

  task automatic load_and_reset(input bit check_clear);
    logic [31:0] v;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < PW; i++) dut_i.u_imem.rom_q[i] = prog[i];
    @(negedge clk);
    if (check_clear) begin
      for (int r = 0; r < 32; r++) begin
        rd_reg(r, v);
        chk("R1", $sformatf("reg %0d in reset", r), v, 32'h0);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic compare_all(input bool_tags);
    logic [31:0] v;
    for (int r = 0; r < 32; r++) begin
      rd_reg(r, v);
      chk(bool_tags ? tag_of(r) : "R11", $sformatf("reg %0d", r), v, ref_rf[r]);
    end
  endtask

  task automatic build_sweep(input logic [31:0] a, input logic [31:0] b);
    for (int i = 0; i < PW; i++) prog[i] = halt_word();
    prog[0]  = enc_i(6'b001111, 5'd0, 5'd1, a[31:16]);
    prog[1]  = enc_i(6'b001101, 5'd1, 5'd1, a[15:0]);
    prog[2]  = enc_i(6'b001111, 5'd0, 5'd2, b[31:16]);
    prog[3]  = enc_i(6'b001101, 5'd2, 5'd2, b[15:0]);
    prog[4]  = enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100001);
    prog[5]  = enc_r(5'd1, 5'd2, 5'd4, 5'd0, 6'b100011);
    prog[6]  = enc_r(5'd1, 5'd2, 5'd5, 5'd0, 6'b100100);
    prog[7]  = enc_r(5'd1, 5'd2, 5'd6, 5'd0, 6'b100101);
    prog[8]  = enc_r(5'd1, 5'd2, 5'd7, 5'd0, 6'b101010);
    prog[9]  = enc_i(6'b001000, 5'd1, 5'd8, b[15:0]);
    prog[10] = enc_i(6'b001011, 5'd1, 5'd9, b[15:0]);
    prog[11] = enc_r(5'd7, 5'd1, 5'd10, b[4:0], 6'b000011);
    prog[12] = enc_r(5'd2, 5'd1, 5'd11, 5'd0, 6'b000111);
    prog[13] = enc_i(6'b001101, 5'd2, 5'd12, a[15:0]);
    prog[14] = enc_i(6'b000100, 5'd1, 5'd2, 16'd1);
    prog[15] = enc_i(6'b001000, 5'd0, 5'd13, 16'd1);
    prog[16] = enc_i(6'b000101, 5'd1, 5'd2, 16'd1);
    prog[17] = enc_i(6'b001000, 5'd0, 5'd14, 16'd1);
    prog[18] = enc_r(5'd1, 5'd2, 5'd0, 5'd0, 6'b100001);
    prog[19] = enc_i(6'b001000, 5'd1, 5'd0, 16'd5);
    prog[20] = 32'h0;
    prog[21] = enc_i(6'b100011, 5'd1, 5'd15, 16'd0);
    prog[22] = enc_r(5'd1, 5'd2, 5'd17, 5'd0, 6'b100000);
    prog[23] = enc_i(6'b001111, 5'd0, 5'd16, a[15:0]);
  endtask

  initial begin
    int steps;
    logic [31:0] v, v2;
    vals[0] = 32'h00000000; vals[1]  = 32'h00000001; vals[2]  = 32'h00000002;
    vals[3] = 32'h00000007; vals[4]  = 32'h7FFFFFFF; vals[5]  = 32'h80000000;
    vals[6] = 32'hFFFFFFFF; vals[7]  = 32'hFFFFFFFE; vals[8]  = 32'h12345678;
    vals[9] = 32'h0000FFFF; vals[10] = 32'hFFFF0000; vals[11] = 32'h80000001;
    #1 rst_n = 1'b0;

    // stated program 1: forward branch not taken
    for (int i = 0; i < PW; i++) prog[i] = halt_word();
    prog[0] = enc_i(6'b001000, 5'd0, 5'd1, 16'd13);
    prog[1] = enc_i(6'b001000, 5'd0, 5'd2, 16'd7);
    prog[2] = enc_i(6'b001011, 5'd1, 5'd3, 16'hFFFF);
    prog[3] = enc_i(6'b000100, 5'd3, 5'd0, 16'd1);
    prog[4] = enc_r(5'd2, 5'd1, 5'd4, 5'd0, 6'b101010);
    prog[5] = enc_r(5'd1, 5'd4, 5'd5, 5'd0, 6'b100100);
    prog[6] = enc_r(5'd1, 5'd5, 5'd4, 5'd0, 6'b100011);
    iss_run(steps);
    load_and_reset(1'b1);
    repeat (steps) @(posedge clk);
    @(negedge clk);
    rd_reg(1, v); chk("R11", "prog1 r1", v, 32'd13);
    rd_reg(2, v); chk("R11", "prog1 r2", v, 32'd7);
    rd_reg(3, v); chk("R11", "prog1 r3", v, 32'd1);
    rd_reg(4, v); chk("R11", "prog1 r4", v, 32'd12);
    rd_reg(5, v); chk("R11", "prog1 r5", v, 32'd1);
    compare_all(1'b0);
    // R10: selection change alone, no clock edge in between
    @(negedge clk);
    dbg_sel = 5'd1; #0.1; v = dbg_val;
    dbg_sel = 5'd2; #0.1; v2 = dbg_val;
    chk("R10", "comb read r1", v, 32'd13);
    chk("R10", "comb read r2", v2, 32'd7);

    // stated program 3: shifts, lui and a backward counted loop
    for (int i = 0; i < PW; i++) prog[i] = halt_word();
    prog[0] = enc_i(6'b001101, 5'd0, 5'd10, 16'd3);
    prog[1] = enc_i(6'b001111, 5'd0, 5'd11, 16'hFFF6);
    prog[2] = enc_r(5'd0, 5'd11, 5'd11, 5'd8, 6'b000011);
    prog[3] = enc_r(5'd10, 5'd11, 5'd11, 5'd0, 6'b000111);
    prog[4] = enc_i(6'b001000, 5'd10, 5'd10, 16'hFFFF);
    prog[5] = enc_i(6'b000101, 5'd10, 5'd0, 16'hFFFD);
    iss_run(steps);
    load_and_reset(1'b1);
    repeat (steps) @(posedge clk);
    @(negedge clk);
    rd_reg(10, v); chk("R11", "prog3 r10", v, 32'd0);
    rd_reg(11, v); chk("R11", "prog3 r11", v, 32'hFFFFFFD8);
    compare_all(1'b0);

    // operand sweep over boundary pairs
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        build_sweep(vals[i], vals[j]);
        iss_run(steps);
        load_and_reset((i + j) % 11 == 0);
        // exactly five edges: instruction 4 done, instruction 5 not yet (R11)
        repeat (5) @(posedge clk);
        @(negedge clk);
        rd_reg(3, v); chk("R11", "after 5 edges r3", v, vals[i] + vals[j]);
        rd_reg(4, v); chk("R11", "after 5 edges r4", v, 32'h0);
        repeat (steps - 5) @(posedge clk);
        @(negedge clk);
        compare_all(1'b1);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule